// File: doc/BRIEF.md
# Watchdog Reset Generator

This block guards a processor against software lockup. Once software turns it on, a free-running interval counter advances every clock, and software must restart it before it reaches the selected interval. If the interval runs out first, the block drives a system reset for a fixed number of clocks and then releases it. A constant fetch start address is presented on a vector output so the processor knows where to begin after reset.

A sticky status bit tells software, after it comes back up, that the last reset was forced by the watchdog. Only an explicit software write of 0 clears this bit. Software can also ask for an internal system reset, for example once in-system programming has finished. That request goes through the same reset sequencer and gives the same pulse, but it leaves the status bit alone. An active-low power-on reset input returns all state to its initial values.

Top module: `wdtResetGen`

## Requirements
- R1: While and after power-on reset (`porN` low), `sysRst`, `wdEn` and `wdFlag` are 0 and `tselQ` is 0.
- R2: With the watchdog on and never restarted, `sysRst` rises exactly 2^(BASE_EXP + STEP_EXP*sel) clock edges after the edge that captures the enable. `sel` is the 2-bit select value, and the defaults BASE_EXP=15 and STEP_EXP=3 give 2^15, 2^18, 2^21 and 2^24.
- R3: A restart strobe zeroes the interval counter on the next edge, so restarting more often than the interval never produces a reset.
- R4: When a restart arrives in the same cycle that the counter reaches its last count, the restart wins: no reset occurs and a full new interval begins.
- R5: Every reset pulse on `sysRst` lasts exactly HOLD_CYC clocks (default 4).
- R6: `resetVec` always carries the fetch start address RESET_VEC (default 16'h8000).
- R7: A watchdog timeout sets `wdFlag` to 1 and clears `wdEn` on the edge that starts the pulse. Later internal resets leave `wdFlag` set.
- R8: `wdFlag` is cleared only by a flag write with `flagData`=0. A flag write with `flagData`=1 has no effect.
- R9: A one-cycle `swRstReq` starts the same pulse on the next edge and does not set `wdFlag`.
- R10: While `sysRst` is high, register writes, restarts and new reset requests are ignored, and the pulse is not lengthened.
- R11: While the watchdog is off, it never asserts `sysRst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| enWr | input | 1 | Write strobe for the enable bit |
| enData | input | 1 | Enable value to write |
| restartWr | input | 1 | Restart strobe, zeroes the interval counter |
| tselWr | input | 1 | Write strobe for the interval select |
| tselData | input | SEL_W | Interval select value to write |
| flagWr | input | 1 | Write strobe for the watchdog-cause flag |
| flagData | input | 1 | Flag write value (only 0 acts) |
| swRstReq | input | 1 | Single-cycle software reset request |
| sysRst | output | 1 | System reset output, active high |
| resetVec | output | VEC_W | Fetch start address after reset |
| wdEn | output | 1 | Readback of the enable bit |
| wdFlag | output | 1 | Sticky flag: last reset came from a timeout |
| tselQ | output | SEL_W | Readback of the interval select |

## Verification
The timeout path is run once for each of the four select codes. Each run measures the edges from enable to reset, which separates a wrong exponent or step from an off-by-one in the terminal compare. Periodic restarts spaced shorter than the interval show that the counter really clears and does not merely pause. A restart placed on the exact terminal cycle shows whether the race is resolved in favour of the restart. Software-triggered resets, issued with the flag both clear and set and with extra strobes during the pulse, separate the two reset sources in how they treat the flag and the pulse length.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the sequencer to the register/counter datapath
  typedef struct packed {
    logic clrCnt;   // zero the interval counter
    logic clrEn;    // drop the enable bit
    logic setFlag;  // record a timeout-caused reset
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_dpath.sv
module wdt_dpath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int STEP_EXP = 3,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  wdtStrobe_t       strb,
  input  logic             blocked,
  input  logic             enWr,
  input  logic             enData,
  input  logic             restartWr,
  input  logic             tselWr,
  input  logic [SEL_W-1:0] tselData,
  input  logic             flagWr,
  input  logic             flagData,
  output logic             expire,
  output logic             wdEn,
  output logic             wdFlag,
  output logic [SEL_W-1:0] tselQ
);
  localparam int NSEL  = 2 ** SEL_W;
  localparam int CNT_W = BASE_EXP + STEP_EXP * (NSEL - 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limM1 [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign limM1[g] = (CNT_W'(1) << (BASE_EXP + STEP_EXP * g)) - CNT_W'(1);
  end

  assign expire = wdEn && (cnt == limM1[tselQ]);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cnt <= '0;
    end else if (strb.clrCnt || !wdEn || (restartWr && !blocked)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdEn <= 1'b0;
    end else if (strb.clrEn) begin
      wdEn <= 1'b0;
    end else if (enWr && !blocked) begin
      wdEn <= enData;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      tselQ <= '0;
    end else if (tselWr && !blocked) begin
      tselQ <= tselData;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdFlag <= 1'b0;
    end else if (strb.setFlag) begin
      wdFlag <= 1'b1;
    end else if (flagWr && !flagData && !blocked) begin
      wdFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       expire,
  input  logic       restartWr,
  input  logic       swRstReq,
  output wdtStrobe_t strb,
  output logic       sysRst
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);

  logic [HC_W-1:0] holdCnt;
  logic            busy;
  logic            wdTrig;
  logic            swTrig;

  assign busy   = (holdCnt != '0);
  assign wdTrig = !busy && expire && !restartWr;
  assign swTrig = !busy && swRstReq;

  always_comb begin
    strb.clrCnt  = wdTrig || swTrig || busy;
    strb.clrEn   = wdTrig || swTrig || busy;
    strb.setFlag = wdTrig;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdCnt <= '0;
    end else if (wdTrig || swTrig) begin
      holdCnt <= HC_W'(HOLD_CYC);
    end else if (busy) begin
      holdCnt <= holdCnt - HC_W'(1);
    end
  end

  assign sysRst = busy;
endmodule

// File: rtl/wdtResetGen.sv
module wdtResetGen
  import wdt_pkg::*;
#(
  parameter int              BASE_EXP  = 15,
  parameter int              STEP_EXP  = 3,
  parameter int              SEL_W     = 2,
  parameter int              HOLD_CYC  = 4,
  parameter int              VEC_W     = 16,
  parameter logic [VEC_W-1:0] RESET_VEC = 16'h8000
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             enWr,
  input  logic             enData,
  input  logic             restartWr,
  input  logic             tselWr,
  input  logic [SEL_W-1:0] tselData,
  input  logic             flagWr,
  input  logic             flagData,
  input  logic             swRstReq,
  output logic             sysRst,
  output logic [VEC_W-1:0] resetVec,
  output logic             wdEn,
  output logic             wdFlag,
  output logic [SEL_W-1:0] tselQ
);
  wdtStrobe_t strb;
  logic       expire;

  wdt_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk       (clk),
    .porN      (porN),
    .expire    (expire),
    .restartWr (restartWr),
    .swRstReq  (swRstReq),
    .strb      (strb),
    .sysRst    (sysRst)
  );

  wdt_dpath #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .SEL_W(SEL_W)) u_dpath (
    .clk       (clk),
    .porN      (porN),
    .strb      (strb),
    .blocked   (sysRst),
    .enWr      (enWr),
    .enData    (enData),
    .restartWr (restartWr),
    .tselWr    (tselWr),
    .tselData  (tselData),
    .flagWr    (flagWr),
    .flagData  (flagData),
    .expire    (expire),
    .wdEn      (wdEn),
    .wdFlag    (wdFlag),
    .tselQ     (tselQ)
  );

  assign resetVec = RESET_VEC;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int HOLD_CYC = 4
) (
  input logic clk,
  input logic porN,
  input logic sysRst,
  input logic swRstReq,
  input logic wdEn,
  input logic wdFlag,
  input logic flagWr,
  input logic flagData
);
  localparam int HW = $clog2(HOLD_CYC + 2);
  logic [HW-1:0] hiCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)       hiCnt <= '0;
    else if (sysRst) hiCnt <= hiCnt + HW'(1);
    else             hiCnt <= '0;
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> (hiCnt == HW'(HOLD_CYC))); // R5

  AST_PULSE_NOT_LONG: assert property (@(posedge clk) disable iff (!porN)
    sysRst |-> (hiCnt < HW'(HOLD_CYC))); // R10

  AST_EN_DROP: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRst) |-> !wdEn); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (wdFlag && !(flagWr && !flagData)) |=> wdFlag); // R8

  AST_SW_START: assert property (@(posedge clk) disable iff (!porN)
    (swRstReq && !sysRst) |=> sysRst); // R9

  AST_SW_NOFLAG: assert property (@(posedge clk) disable iff (!porN)
    (swRstReq && !sysRst && !wdEn && !wdFlag) |=> !wdFlag); // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!porN)
    (!wdEn && !swRstReq && !sysRst) |=> !sysRst); // R11
endmodule

bind wdtResetGen wdt_checker #(.HOLD_CYC(HOLD_CYC)) u_wdtChk (
  .clk      (clk),
  .porN     (porN),
  .sysRst   (sysRst),
  .swRstReq (swRstReq),
  .wdEn     (wdEn),
  .wdFlag   (wdFlag),
  .flagWr   (flagWr),
  .flagData (flagData)
);

// File: tb/test_wdtResetGen.sv
module test_wdtResetGen;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 6;
  localparam int STEP_EXP   = 3;
  localparam int HOLD       = 4;

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] lim;
  } vec_t;

  // select code -> expected interval = 2^(6 + 3*sel)
  localparam vec_t VECS [4] = '{
    '{2'd0, 32'd64},
    '{2'd1, 32'd512},
    '{2'd2, 32'd4096},
    '{2'd3, 32'd32768}
  };

  logic clk = 1'b0;
  logic porN, enWr, enData, restartWr, tselWr, flagWr, flagData, swRstReq;
  logic [1:0]  tselData;
  logic        sysRst, wdEn, wdFlag;
  logic [15:0] resetVec;
  logic [1:0]  tselQ;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdtResetGen #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)) i_wdtResetGen (
    .clk(clk), .porN(porN), .enWr(enWr), .enData(enData), .restartWr(restartWr),
    .tselWr(tselWr), .tselData(tselData), .flagWr(flagWr), .flagData(flagData),
    .swRstReq(swRstReq), .sysRst(sysRst), .resetVec(resetVec), .wdEn(wdEn),
    .wdFlag(wdFlag), .tselQ(tselQ)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idleInputs();
    enWr = 0; enData = 0; restartWr = 0; tselWr = 0; tselData = 0;
    flagWr = 0; flagData = 0; swRstReq = 0;
  endtask

  task automatic doPor();
    porN = 0;
    idleInputs();
    repeat (3) tick();
    porN = 1;
    tick();
  endtask

  task automatic setSel(input logic [1:0] s);
    tselWr = 1; tselData = s; tick(); tselWr = 0;
  endtask

  task automatic enableWd();
    enWr = 1; enData = 1; tick(); enWr = 0; enData = 0;
  endtask

  task automatic restartWd();
    restartWr = 1; tick(); restartWr = 0;
  endtask

  task automatic clearFlag(input logic d);
    flagWr = 1; flagData = d; tick(); flagWr = 0; flagData = 0;
  endtask

  // edges from the last capture edge until sysRst is seen high
  task automatic edgesToReset(input int maxEdges, output int n);
    n = 0;
    while (!sysRst && n < maxEdges) begin
      tick();
      n++;
    end
  endtask

  task automatic pulseWidth(output int w);
    w = 0;
    while (sysRst && w < 20) begin
      tick();
      w++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int w;
    int seenRst;

    doPor();
    // R1 reset state
    check("R1 sysRst", sysRst, 0);
    check("R1 wdEn", wdEn, 0);
    check("R1 wdFlag", wdFlag, 0);
    check("R1 tselQ", tselQ, 0);
    check("R6 resetVec", resetVec, 16'h8000);

    // Table: every interval select
    foreach (VECS[i]) begin
      setSel(VECS[i].sel);
      check("R2 tsel readback", tselQ, VECS[i].sel);
      enableWd();
      edgesToReset(VECS[i].lim + 10, n);
      check("R2 timeout edges", n, VECS[i].lim);
      check("R7 enable dropped", wdEn, 0);
      check("R7 flag set", wdFlag, 1);
      check("R6 resetVec during reset", resetVec, 16'h8000);
      pulseWidth(w);
      check("R5 pulse width", w, HOLD);
      clearFlag(1'b0);
      check("R8 flag cleared by write 0", wdFlag, 0);
    end

    // R8: writing 1 to a clear flag does nothing
    clearFlag(1'b1);
    check("R8 write 1 on clear flag", wdFlag, 0);

    // R9: software reset with flag clear
    swRstReq = 1; tick(); swRstReq = 0;
    check("R9 sw reset starts next edge", sysRst, 1);
    pulseWidth(w);
    check("R9 sw pulse width", w, HOLD - 1 + 1);
    check("R9 sw reset leaves flag clear", wdFlag, 0);

    // R3: periodic restarts keep the system out of reset
    setSel(2'd0);
    enableWd();
    seenRst = 0;
    for (int k = 0; k < 6; k++) begin
      repeat (40) begin
        tick();
        if (sysRst) seenRst++;
      end
      restartWd();
      if (sysRst) seenRst++;
    end
    check("R3 no reset under periodic restart", seenRst, 0);

    // R4: restart exactly on the terminal cycle
    restartWd();
    repeat (63) tick();
    restartWr = 1; tick(); restartWr = 0;
    check("R4 race: no reset", sysRst, 0);
    edgesToReset(200, n);
    check("R4 full interval after race restart", n, 64);
    check("R7 flag set again", wdFlag, 1);
    pulseWidth(w);

    // R8: writing 1 to a set flag does nothing
    clearFlag(1'b1);
    check("R8 write 1 on set flag", wdFlag, 1);

    // R7/R10: sw reset keeps flag; writes and requests during pulse ignored
    swRstReq = 1; tick(); swRstReq = 0;
    check("R10 pulse begun", sysRst, 1);
    tick();
    swRstReq = 1; enWr = 1; enData = 1; tselWr = 1; tselData = 2'd3;
    flagWr = 1; flagData = 0;
    tick();
    idleInputs();
    w = 2;
    while (sysRst && w < 20) begin tick(); w++; end
    check("R10 pulse not lengthened", w, HOLD);
    check("R10 enable write ignored", wdEn, 0);
    check("R10 select write ignored", tselQ, 0);
    check("R10 flag clear ignored / R7 kept", wdFlag, 1);

    // R11: disabled watchdog stays quiet
    seenRst = 0;
    repeat (300) begin
      tick();
      if (sysRst) seenRst++;
    end
    check("R11 no reset while off", seenRst, 0);

    // R1: power-on reset clears the flag
    doPor();
    check("R1 flag cleared by POR", wdFlag, 0);
    check("R1 enable after POR", wdEn, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule